// File: doc/BRIEF.md
# SPI Parity Frame Transceiver

This block runs one 16-bit full-duplex SPI exchange with a smart low-side output driver on behalf of a host. The host presents a request that holds a write flag, a register address and a data byte. The block assembles the outgoing frame and inserts an odd-parity bit inside it. It clocks the frame out most significant bit first while it shifts the reply in. It then hands back the reply's address and data fields together with three status flags: a parity error, a communication fault and a global fault.

The serial side uses SPI mode 1. SCLK idles low, MOSI changes on the rising edge and MISO is sampled on the falling edge. The chip select stays low across all sixteen bits and is framed by a lead-in and a lead-out time. The SCLK rate comes from a divider value that is captured with each request. A busy level keeps new requests out while a transfer is under way. A one-cycle done pulse marks the moment the returned fields are valid.

Top module: `spi_pf_xfer`

## Requirements
- R1: Outgoing frame layout: bit 15 is the write flag (1 = write, 0 = read), bit 14 is parity, bits 13:12 are driven 0, bits 11:8 carry the address, and bits 7:0 carry the write data on a write and 0 on a read.
- R2: The outgoing parity bit is set so that the count of ones across all 16 frame bits, parity included, is odd.
- R3: SCLK idles low and gives exactly 16 rising edges per transfer. MOSI changes only on rising edges and is stable across each falling edge. Bits go out and come in most significant bit first, with MISO captured on falling edges.
- R4: The chip select is high while idle. It is low on every SCLK edge of a transfer, falls at least one SCLK period before the first rising edge, and rises one SCLK period after the last falling edge.
- R5: Each SCLK half period lasts div_i+1 system cycles. The value of div_i is captured when the request is accepted, and later changes have no effect on the running transfer.
- R6: A request is accepted on a rising clock edge with req_i high while busy_o is low. busy_o then stays high up to and including the done cycle. done_o is high for exactly one cycle, 36*(div+1) cycles after the accepting edge.
- R7: A request raised while busy_o is high is ignored. It changes neither the frame sent, the transfer length nor the results.
- R8: perr_o is set when the received 16-bit frame holds an even number of ones.
- R9: cfault_o reports received bit 13 unless ign_cf_i was high when the request was accepted, in which case it is 0. gfault_o reports received bit 12.
- R10: rx_addr_o carries received bits 11:8 and rx_data_o carries received bits 7:0. All results are valid from the done cycle and hold until the next done.
- R11: After reset cs_n_o is 1, and sclk_o, mosi_o, busy_o, done_o and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken when not busy |
| wr_i | input | 1 | 1 = write request, 0 = read request |
| addr_i | input | ADDR_W | Register address to place in the frame |
| wdata_i | input | DATA_W | Write data byte |
| div_i | input | DIV_W | SCLK half period minus one, in system cycles |
| ign_cf_i | input | 1 | Suppress the communication-fault report for this request |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| rx_addr_o | output | ADDR_W | Address field of the reply |
| rx_data_o | output | DATA_W | Data field of the reply |
| perr_o | output | 1 | Reply failed the odd-parity check |
| cfault_o | output | 1 | Communication fault flagged in the reply |
| gfault_o | output | 1 | Global fault flagged in the reply |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The done pulse and every result field become valid exactly 36*(div+1) system cycles after the edge that accepts the request. The bench counts falling clock edges from that accepting edge and requires done to appear at precisely that count. It reads the results in the same half cycle and checks again one cycle later that busy and done have dropped. A device model driven only by SCLK and chip-select edges recovers the outgoing frame and supplies the reply. This keeps the frame and bit-order checks independent of the system-cycle timing. Result hold is checked ten cycles after done.

// File: rtl/spi_pf_pkg.sv
package spi_pf_pkg;

   // number of non-payload bits in a frame: write flag, parity, two fault flags
   localparam int unsigned FLAG_BITS = 4;

   // half periods spent before the first and after the last SCLK edge
   localparam int unsigned GUARD_HALVES = 2;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LEAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_TRAIL = 3'd3,
      ST_DONE  = 3'd4
   } xfer_state_t;

   typedef struct packed {
      logic perr;
      logic cfault;
      logic gfault;
   } rx_flags_t;

endpackage

// File: rtl/spi_pf_tick.sv
module spi_pf_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] limit_i,
   output logic             tick_o
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_pf_tick: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q == limit_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == limit_i);

   // R5
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && limit_i != '0 && run_i) |=> !tick_o);

endmodule

// File: rtl/spi_pf_codec.sv
module spi_pf_codec import spi_pf_pkg::*; #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned FRAME_W = ADDR_W + DATA_W + FLAG_BITS
) (
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [FRAME_W-1:0] tx_frame_o,
   input  logic [FRAME_W-1:0] rx_frame_i,
   input  logic               ign_cf_i,
   output logic [ADDR_W-1:0]  rx_addr_o,
   output logic [DATA_W-1:0]  rx_data_o,
   output rx_flags_t          rx_flags_o
);

   localparam int unsigned ADDR_LO = DATA_W;
   localparam int unsigned GF_POS  = DATA_W + ADDR_W;
   localparam int unsigned CF_POS  = GF_POS + 1;
   localparam int unsigned PAR_POS = GF_POS + 2;
   localparam int unsigned RW_POS  = GF_POS + 3;

   generate
      if (FRAME_W != ADDR_W + DATA_W + FLAG_BITS) begin : g_bad_frame
         $error("spi_pf_codec: FRAME_W does not match field widths");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_fields
         $error("spi_pf_codec: field widths must be positive");
      end
   endgenerate

   logic [FRAME_W-1:0] body;

   always_comb begin
      body                           = '0;
      body[RW_POS]                   = wr_i;
      body[GF_POS+ADDR_W-1-ADDR_W+1 +: 0+1] = 1'b0;
      body[ADDR_LO +: ADDR_W]        = addr_i;
      body[0 +: DATA_W]              = wr_i ? wdata_i : '0;
      tx_frame_o                     = body;
      // odd total: the parity bit fills in when the body count is even
      tx_frame_o[PAR_POS]            = ~(^body);
   end

   assign rx_addr_o         = rx_frame_i[ADDR_LO +: ADDR_W];
   assign rx_data_o         = rx_frame_i[0 +: DATA_W];
   assign rx_flags_o.perr   = ~(^rx_frame_i);
   assign rx_flags_o.cfault = rx_frame_i[CF_POS] & ~ign_cf_i;
   assign rx_flags_o.gfault = rx_frame_i[GF_POS];

   // R2
   always_comb begin
      if (!$isunknown({wr_i, addr_i, wdata_i})) begin
         tx_odd_parity_chk: assert (^tx_frame_o == 1'b1);
      end
   end

endmodule

// File: rtl/spi_pf_xfer.sv
module spi_pf_xfer import spi_pf_pkg::*; #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              ign_cf_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] rx_addr_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              perr_o,
   output logic              cfault_o,
   output logic              gfault_o,
   output logic              sclk_o,
   output logic              cs_n_o,
   output logic              mosi_o,
   input  logic              miso_i
);

   localparam int unsigned FRAME_W = ADDR_W + DATA_W + FLAG_BITS;
   localparam int unsigned CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   generate
      if (FRAME_W < 2) begin : g_bad_width
         $error("spi_pf_xfer: frame too short");
      end
      if (GUARD_HALVES != 2) begin : g_bad_guard
         $error("spi_pf_xfer: guard logic assumes two half periods");
      end
   endgenerate

   xfer_state_t        state_q;
   logic [DIV_W-1:0]   div_q;
   logic               ign_q;
   logic [FRAME_W-1:0] tx_sh_q;
   logic [FRAME_W-1:0] rx_sh_q;
   logic [CNT_W-1:0]   bit_q;
   logic               half_q;
   logic               sclk_q;
   logic               cs_n_q;
   logic               mosi_q;

   logic [ADDR_W-1:0]  rx_addr_q;
   logic [DATA_W-1:0]  rx_data_q;
   rx_flags_t          flags_q;

   logic [FRAME_W-1:0] tx_frame;
   logic [ADDR_W-1:0]  dec_addr;
   logic [DATA_W-1:0]  dec_data;
   rx_flags_t          dec_flags;
   logic               run;
   logic               tick;

   assign run = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);

   spi_pf_tick #(
      .DIV_W (DIV_W)
   ) tick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .limit_i (div_q),
      .tick_o  (tick)
   );

   spi_pf_codec #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .FRAME_W (FRAME_W)
   ) codec_i (
      .wr_i       (wr_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .tx_frame_o (tx_frame),
      .rx_frame_i (rx_sh_q),
      .ign_cf_i   (ign_q),
      .rx_addr_o  (dec_addr),
      .rx_data_o  (dec_data),
      .rx_flags_o (dec_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         div_q     <= '0;
         ign_q     <= 1'b0;
         tx_sh_q   <= '0;
         rx_sh_q   <= '0;
         bit_q     <= '0;
         half_q    <= 1'b0;
         sclk_q    <= 1'b0;
         cs_n_q    <= 1'b1;
         mosi_q    <= 1'b0;
         rx_addr_q <= '0;
         rx_data_q <= '0;
         flags_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  tx_sh_q <= tx_frame;
                  div_q   <= div_i;
                  ign_q   <= ign_cf_i;
                  cs_n_q  <= 1'b0;
                  half_q  <= 1'b0;
                  bit_q   <= '0;
                  state_q <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  if (half_q) begin
                     half_q  <= 1'b0;
                     state_q <= ST_SHIFT;
                  end else begin
                     half_q <= 1'b1;
                  end
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     // launch edge: present the next bit
                     sclk_q  <= 1'b1;
                     mosi_q  <= tx_sh_q[FRAME_W-1];
                     tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
                  end else begin
                     // capture edge: take the device's bit
                     sclk_q  <= 1'b0;
                     rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso_i};
                     if (bit_q == LAST_BIT) begin
                        bit_q   <= '0;
                        state_q <= ST_TRAIL;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end
            end
            ST_TRAIL: begin
               if (tick) begin
                  if (half_q) begin
                     half_q    <= 1'b0;
                     cs_n_q    <= 1'b1;
                     mosi_q    <= 1'b0;
                     rx_addr_q <= dec_addr;
                     rx_data_q <= dec_data;
                     flags_q   <= dec_flags;
                     state_q   <= ST_DONE;
                  end else begin
                     half_q <= 1'b1;
                  end
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);
   assign sclk_o    = sclk_q;
   assign cs_n_o    = cs_n_q;
   assign mosi_o    = mosi_q;
   assign rx_addr_o = rx_addr_q;
   assign rx_data_o = rx_data_q;
   assign perr_o    = flags_q.perr;
   assign cfault_o  = flags_q.cfault;
   assign gfault_o  = flags_q.gfault;

   // R4
   cs_low_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !cs_n_o);

   // R11
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && !sclk_o));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R3
   mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

   // R5
   div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(div_q));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && !$past(done_o)) |-> $stable(rx_data_o));

endmodule

// File: tb/spi_pf_xfer_tb.sv
module spi_pf_xfer_tb_top;

   typedef struct packed {
      logic        wr;
      logic [3:0]  addr;
      logic [7:0]  wdata;
      logic [7:0]  div;
      logic [15:0] reply;
      logic        ign;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 4'h1, 8'hA5, 8'd0, 16'hB2C3, 1'b0},
      '{1'b0, 4'h7, 8'h00, 8'd1, 16'h2881, 1'b0},
      '{1'b0, 4'h8, 8'h3C, 8'd3, 16'h2881, 1'b1},
      '{1'b1, 4'hF, 8'hFF, 8'd2, 16'h1F00, 1'b0},
      '{1'b1, 4'h0, 8'h00, 8'd0, 16'h0000, 1'b0},
      '{1'b0, 4'h3, 8'h5A, 8'd0, 16'hFFFF, 1'b0},
      '{1'b1, 4'h2, 8'h81, 8'd5, 16'h7FFF, 1'b1},
      '{1'b0, 4'h4, 8'hC3, 8'd0, 16'h8001, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [3:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic [7:0] div_i = '0;
   logic       ign_i = 1'b0;
   logic       miso = 1'b0;
   logic       busy_o, done_o, perr_o, cfault_o, gfault_o;
   logic       sclk_o, cs_n_o, mosi_o;
   logic [3:0] rx_addr_o;
   logic [7:0] rx_data_o;

   int n_chk = 0;
   int n_bad = 0;

   // device model state
   logic [15:0] sl_reply = '0;
   logic [15:0] cap = '0;
   int sl_idx = 0;
   int rises = 0;
   int cs_viol = 0;

   always #5 clk = ~clk;

   spi_pf_xfer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .wr_i      (wr_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .div_i     (div_i),
      .ign_cf_i  (ign_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .rx_addr_o (rx_addr_o),
      .rx_data_o (rx_data_o),
      .perr_o    (perr_o),
      .cfault_o  (cfault_o),
      .gfault_o  (gfault_o),
      .sclk_o    (sclk_o),
      .cs_n_o    (cs_n_o),
      .mosi_o    (mosi_o),
      .miso_i    (miso)
   );

   always @(negedge cs_n_o) begin
      sl_idx = 0;
      rises  = 0;
      cap    = '0;
   end

   always @(posedge sclk_o) begin
      if (cs_n_o) cs_viol++;
      if (sl_idx < 16) miso = sl_reply[15 - sl_idx];
      sl_idx++;
      rises++;
   end

   always @(negedge sclk_o) begin
      cap = {cap[14:0], mosi_o};
   end

   function automatic int ones16(input logic [15:0] v);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic logic [15:0] exp_tx(input vec_t v);
      logic [15:0] f;
      f = {v.wr, 1'b0, 2'b00, v.addr, (v.wr ? v.wdata : 8'h00)};
      if (ones16(f) % 2 == 0) f[14] = 1'b1;
      return f;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic do_xfer(input vec_t v, input bit inject);
      int k;
      int due;
      logic [15:0] et;
      et  = exp_tx(v);
      due = 36 * (int'(v.div) + 1);
      @(negedge clk);
      wr_i = v.wr; addr_i = v.addr; wdata_i = v.wdata;
      div_i = v.div; ign_i = v.ign; sl_reply = v.reply; req_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_i = 1'b0;
      chk(busy_o == 1'b1, "R6 busy after accept", 32'(busy_o), 32'd1);
      k = 0;
      while (!done_o && k < 3000) begin
         if (inject && k == 5) begin
            // R7: second request while busy, with a new divider (R5)
            req_i = 1'b1; wr_i = ~v.wr; addr_i = ~v.addr;
            wdata_i = ~v.wdata; div_i = 8'd3; ign_i = ~v.ign;
         end
         if (inject && k == 6) req_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         k++;
      end
      chk(k == due, inject ? "R7 R5 done latency" : "R5 R6 done latency", 32'(k), 32'(due));
      chk(cap == et, inject ? "R7 frame sent" : "R1 R2 frame sent", 32'(cap), 32'(et));
      chk(rises == 16, "R3 sclk rising edges", 32'(rises), 32'd16);
      chk(cs_viol == 0, "R4 cs low on sclk", 32'(cs_viol), 32'd0);
      chk(rx_addr_o == v.reply[11:8], "R10 rx address", 32'(rx_addr_o), 32'(v.reply[11:8]));
      chk(rx_data_o == v.reply[7:0], "R10 rx data", 32'(rx_data_o), 32'(v.reply[7:0]));
      chk(perr_o == (ones16(v.reply) % 2 == 0), "R8 parity error",
          32'(perr_o), 32'(ones16(v.reply) % 2 == 0));
      chk(cfault_o == (v.reply[13] & ~v.ign), "R9 comm fault",
          32'(cfault_o), 32'(v.reply[13] & ~v.ign));
      chk(gfault_o == v.reply[12], "R9 global fault", 32'(gfault_o), 32'(v.reply[12]));
      @(posedge clk);
      @(negedge clk);
      chk(!done_o && !busy_o, "R6 done one cycle then idle",
          32'({done_o, busy_o}), 32'd0);
      chk(cs_n_o && !sclk_o, "R4 lines idle after done",
          32'({cs_n_o, sclk_o}), 32'h2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 32'd1, 32'd0);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state, R3 idle low clock
      chk(cs_n_o == 1'b1, "R11 cs_n reset", 32'(cs_n_o), 32'd1);
      chk(sclk_o == 1'b0 && mosi_o == 1'b0, "R11 R3 sclk mosi reset",
          32'({sclk_o, mosi_o}), 32'd0);
      chk(!busy_o && !done_o, "R11 busy done reset", 32'({busy_o, done_o}), 32'd0);
      chk({rx_addr_o, rx_data_o, perr_o, cfault_o, gfault_o} == '0,
          "R11 results reset", 32'({rx_addr_o, rx_data_o}), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         do_xfer(VECS[i], 1'b0);
      end

      // R10: results hold after done while idle inputs wiggle
      wdata_i = 8'h11; addr_i = 4'h9;
      repeat (10) @(negedge clk);
      chk(rx_data_o == VECS[NVEC-1].reply[7:0], "R10 data held",
          32'(rx_data_o), 32'(VECS[NVEC-1].reply[7:0]));
      chk(rx_addr_o == VECS[NVEC-1].reply[11:8], "R10 address held",
          32'(rx_addr_o), 32'(VECS[NVEC-1].reply[11:8]));

      // R7 and R5: request and divider change during a transfer
      do_xfer(VECS[1], 1'b1);
      do_xfer(VECS[3], 1'b1);

      summary();
   end

endmodule